// File: doc/BRIEF.md
# Memory Tag Check Unit

This unit keeps a 4-bit allocation tag for each 16-byte granule of one small memory region, and it checks every load or store against those tags. A pointer carries its own 4-bit tag in the top byte of its 64-bit address. The unit removes the top byte before it finds the region and the granule, then compares the pointer tag with the stored tag of each granule that the access touches. If the tags differ, the access faults.

An allocator programs tags through a range-write port. The port names a first granule, a granule count and a tag, and the unit writes one granule per cycle. When zero-fill is requested, the unit also raises a strobe for each granule, so that the data store beside it can clear that granule. While a range write is in progress, accesses are stalled.

A fault is reported in one of two ways. In precise mode it is flagged together with the access completion. In deferred mode it is collected in a sticky record that holds the first faulting address, and software clears that record with a write-one-to-clear pulse.

Top module: `mtag_unit`

## Requirements
- R1: After reset, every stored tag is 0, `tw_busy` is 0, `fault_pending` is 0 and `acc_done` is 0.
- R2: The pointer tag is address bits [59:56]. Bits [63:60] take no part in the check. Bits [63:56] take no part in the region test or the granule index, which is (addr[55:0] - REGION_BASE) / 16.
- R3: An access accepted on a clock edge (`acc_valid` and `acc_ready` both high) raises `acc_done` for one cycle after that edge. In precise mode `acc_fault` rises in the same cycle exactly when a checked granule holds a tag that differs from the pointer tag.
- R4: An access never faults when `chk_en` is 0. A granule that lies outside [REGION_BASE, REGION_BASE + 16*GRANULES) is never checked.
- R5: An access covers the bytes addr to addr+`acc_len_m1`. When that span crosses into the next granule, both granules are checked, and a mismatch in either one faults the access.
- R6: A range write with a nonzero count is accepted when `tw_busy` is low. It holds `tw_busy` high for exactly `count` cycles, and writes granules first, first+1, and so on, wrapping modulo GRANULES. A count of 0 does nothing. `tw_valid` is ignored while the unit is busy.
- R7: While `tw_busy` is high, `acc_ready` is low, and an access that is presented produces no `acc_done`.
- R8: During a range write that requests zero-fill, `zf_valid` is high in every busy cycle, and `zf_gran` names the granule written in that cycle. Without zero-fill, `zf_valid` stays low.
- R9: In deferred mode a mismatch leaves `acc_fault` low. It sets `fault_pending`, and the first faulting address and write flag are kept until `fault_clr` arrives. If a clear and a new fault fall on the same edge, the new fault is recorded.
- R10: After a granule is retagged with a different value, an access through a pointer that still carries the old tag faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chk_en | input | 1 | Tag checking enabled for the region |
| precise_mode | input | 1 | 1: report with the access, 0: deferred sticky record |
| tw_valid | input | 1 | Start a tag range write |
| tw_first | input | IDX_W | First granule index of the range |
| tw_count | input | IDX_W+1 | Number of granules to write |
| tw_tag | input | 4 | Tag value to store |
| tw_zero_fill | input | 1 | Request per-granule zero-fill strobes |
| tw_busy | output | 1 | Range write in progress |
| zf_valid | output | 1 | Zero-fill strobe for granule `zf_gran` |
| zf_gran | output | IDX_W | Granule being written this cycle |
| acc_valid | input | 1 | Access request |
| acc_ready | output | 1 | Access can be accepted |
| acc_addr | input | 64 | Tagged access address |
| acc_len_m1 | input | 4 | Access length in bytes minus one |
| acc_write | input | 1 | 1 for a store, 0 for a load |
| acc_done | output | 1 | Access was checked (one cycle after acceptance) |
| acc_fault | output | 1 | Precise fault for the completed access |
| fault_clr | input | 1 | Write-one-to-clear for the deferred record |
| fault_pending | output | 1 | Deferred fault recorded |
| fault_addr | output | 64 | Address of the first deferred fault |
| fault_write | output | 1 | Write flag of the first deferred fault |

## Verification
The bench goes through every granule against all sixteen pointer tags, and it changes the top nibble each time. A design that compared bits [63:60], or that indexed with the top byte included, would then report faults on legal accesses. Accesses that straddle two granules are run at every boundary, including the one at the end of the region. A unit that checked only the first granule would miss mismatches in the second one, and a unit that checked past the region end would fault on memory that carries no tags.

A range write that wraps past the last granule tests the modulo index and the exact busy length. Stalled accesses during that write must produce no completion. The deferred record is exercised with a second fault, which must not overwrite the first address, and with a clear that lands on the same edge as a new fault.

// File: rtl/mtag_pkg.sv
package mtag_pkg;
  localparam int TAG_W      = 4;
  localparam int GRAN_SHIFT = 4;
  localparam int VA_W       = 56;

  function automatic logic [VA_W-1:0] untag(input logic [63:0] a);
    return a[VA_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] ptr_tag(input logic [63:0] a);
    return a[59:56];
  endfunction

  function automatic logic [VA_W-1:0] last_byte(input logic [VA_W-1:0] va,
                                                input logic [3:0] len_m1);
    return va + {{(VA_W-4){1'b0}}, len_m1};
  endfunction
endpackage

// File: rtl/mtag_store.sv
module mtag_store
  import mtag_pkg::*;
#(
  parameter int GRANULES = 64,
  localparam int IDX_W = $clog2(GRANULES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tw_valid,
  input  logic [IDX_W-1:0] tw_first,
  input  logic [IDX_W:0]   tw_count,
  input  logic [TAG_W-1:0] tw_tag,
  input  logic             tw_zero_fill,
  output logic             busy,
  output logic             zf_valid,
  output logic [IDX_W-1:0] zf_gran,
  input  logic [IDX_W-1:0] rd_idx [2],
  output logic [TAG_W-1:0] rd_tag [2]
);
  logic [TAG_W-1:0] tag_q [GRANULES];
  logic             busy_q;
  logic [IDX_W-1:0] cur_q;
  logic [IDX_W:0]   left_q;
  logic [TAG_W-1:0] tag_l;
  logic             zf_l;
  logic             start;

  assign start = tw_valid && !busy_q && (tw_count != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cur_q  <= '0;
      left_q <= '0;
      tag_l  <= '0;
      zf_l   <= 1'b0;
      for (int i = 0; i < GRANULES; i++) tag_q[i] <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cur_q  <= tw_first;
      left_q <= tw_count;
      tag_l  <= tw_tag;
      zf_l   <= tw_zero_fill;
    end else if (busy_q) begin
      tag_q[cur_q] <= tag_l;
      cur_q        <= cur_q + 1'b1;
      left_q       <= left_q - 1'b1;
      if (left_q == 1) busy_q <= 1'b0;
    end
  end

  assign busy     = busy_q;
  assign zf_valid = busy_q && zf_l;
  assign zf_gran  = cur_q;

  for (genvar k = 0; k < 2; k++) begin : g_rd
    assign rd_tag[k] = tag_q[rd_idx[k]];
  end
endmodule

// File: rtl/mtag_check.sv
module mtag_check
  import mtag_pkg::*;
#(
  parameter int GRANULES = 64,
  parameter logic [VA_W-1:0] REGION_BASE = 56'h0000_0000_1000_0000,
  localparam int IDX_W = $clog2(GRANULES)
) (
  input  logic [63:0]      addr,
  input  logic [3:0]       len_m1,
  input  logic             en,
  output logic [IDX_W-1:0] idx [2],
  input  logic [TAG_W-1:0] gran_tag [2],
  output logic             mismatch
);
  localparam logic [VA_W-1:0] SPAN = VA_W'(GRANULES) << GRAN_SHIFT;

  logic [VA_W-1:0]  va   [2];
  logic [VA_W-1:0]  off  [2];
  logic [1:0]       in_rgn;
  logic [1:0]       bad;
  logic [TAG_W-1:0] ptag;

  assign ptag  = ptr_tag(addr);
  assign va[0] = untag(addr);
  assign va[1] = last_byte(untag(addr), len_m1);

  for (genvar k = 0; k < 2; k++) begin : g_lane
    assign off[k]    = va[k] - REGION_BASE;
    assign in_rgn[k] = (va[k] >= REGION_BASE) && (off[k] < SPAN);
    assign idx[k]    = off[k][IDX_W+GRAN_SHIFT-1:GRAN_SHIFT];
    assign bad[k]    = in_rgn[k] && (gran_tag[k] != ptag);
  end

  assign mismatch = en && (|bad);
endmodule

// File: rtl/mtag_report.sv
module mtag_report (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_fire,
  input  logic        mismatch,
  input  logic        precise,
  input  logic [63:0] addr,
  input  logic        wr,
  input  logic        clr,
  output logic        new_fault,
  output logic        done,
  output logic        fault,
  output logic        pending,
  output logic [63:0] f_addr,
  output logic        f_wr
);
  assign new_fault = acc_fire && mismatch && !precise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done    <= 1'b0;
      fault   <= 1'b0;
      pending <= 1'b0;
      f_addr  <= '0;
      f_wr    <= 1'b0;
    end else begin
      done    <= acc_fire;
      fault   <= acc_fire && mismatch && precise;
      pending <= (pending && !clr) || new_fault;
      if (new_fault && (!pending || clr)) begin
        f_addr <= addr;
        f_wr   <= wr;
      end
    end
  end
endmodule

// File: rtl/mtag_unit.sv
module mtag_unit
  import mtag_pkg::*;
#(
  parameter int GRANULES = 64,
  parameter logic [55:0] REGION_BASE = 56'h0000_0000_1000_0000,
  localparam int IDX_W = $clog2(GRANULES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chk_en,
  input  logic             precise_mode,
  input  logic             tw_valid,
  input  logic [IDX_W-1:0] tw_first,
  input  logic [IDX_W:0]   tw_count,
  input  logic [3:0]       tw_tag,
  input  logic             tw_zero_fill,
  output logic             tw_busy,
  output logic             zf_valid,
  output logic [IDX_W-1:0] zf_gran,
  input  logic             acc_valid,
  output logic             acc_ready,
  input  logic [63:0]      acc_addr,
  input  logic [3:0]       acc_len_m1,
  input  logic             acc_write,
  output logic             acc_done,
  output logic             acc_fault,
  input  logic             fault_clr,
  output logic             fault_pending,
  output logic [63:0]      fault_addr,
  output logic             fault_write
);
  logic [IDX_W-1:0] lane_idx [2];
  logic [TAG_W-1:0] lane_tag [2];
  logic             acc_fire;
  logic             tag_mismatch;
  logic             rpt_new_fault;

  assign acc_ready = !tw_busy;
  assign acc_fire  = acc_valid && acc_ready;

  mtag_store #(.GRANULES(GRANULES)) u_store (
    .clk, .rst_n,
    .tw_valid, .tw_first, .tw_count, .tw_tag, .tw_zero_fill,
    .busy(tw_busy), .zf_valid, .zf_gran,
    .rd_idx(lane_idx), .rd_tag(lane_tag)
  );

  mtag_check #(.GRANULES(GRANULES), .REGION_BASE(REGION_BASE)) u_check (
    .addr(acc_addr), .len_m1(acc_len_m1), .en(chk_en),
    .idx(lane_idx), .gran_tag(lane_tag), .mismatch(tag_mismatch)
  );

  mtag_report u_report (
    .clk, .rst_n,
    .acc_fire, .mismatch(tag_mismatch), .precise(precise_mode),
    .addr(acc_addr), .wr(acc_write), .clr(fault_clr),
    .new_fault(rpt_new_fault), .done(acc_done), .fault(acc_fault),
    .pending(fault_pending), .f_addr(fault_addr), .f_wr(fault_write)
  );
endmodule

// File: rtl/mtag_chk.sv
module mtag_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        chk_en,
  input logic        precise_mode,
  input logic        tw_busy,
  input logic        zf_valid,
  input logic        acc_valid,
  input logic        acc_done,
  input logic        acc_fault,
  input logic        fault_clr,
  input logic        fault_pending,
  input logic [63:0] fault_addr,
  input logic        new_fault
);
  // R7
  stall_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && tw_busy |=> !acc_done);
  // R3
  fault_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fault |-> acc_done);
  // R9
  deferred_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fault |-> $past(precise_mode));
  // R9
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_pending && !fault_clr |=> fault_pending && $stable(fault_addr));
  // R9
  record_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    new_fault |=> fault_pending);
  // R8
  zf_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zf_valid |-> tw_busy);
  // R4
  disabled_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fault |-> $past(chk_en));
endmodule

bind mtag_unit mtag_chk u_chk (
  .clk(clk), .rst_n(rst_n), .chk_en(chk_en), .precise_mode(precise_mode),
  .tw_busy(tw_busy), .zf_valid(zf_valid), .acc_valid(acc_valid),
  .acc_done(acc_done), .acc_fault(acc_fault), .fault_clr(fault_clr),
  .fault_pending(fault_pending), .fault_addr(fault_addr),
  .new_fault(rpt_new_fault)
);

// File: tb/test_mtag_unit.sv
module test_mtag_unit;
  localparam int G = 64;
  localparam int IW = 6;
  localparam logic [55:0] BASE = 56'h0000_0000_1000_0000;

  logic clk = 0, rst_n = 0;
  logic chk_en = 1, precise_mode = 1;
  logic tw_valid = 0, tw_zero_fill = 0;
  logic [IW-1:0] tw_first = '0;
  logic [IW:0] tw_count = '0;
  logic [3:0] tw_tag = '0;
  logic tw_busy, zf_valid;
  logic [IW-1:0] zf_gran;
  logic acc_valid = 0, acc_write = 0, fault_clr = 0;
  logic acc_ready, acc_done, acc_fault, fault_pending, fault_write;
  logic [63:0] acc_addr = '0, fault_addr;
  logic [3:0] acc_len_m1 = '0;

  int nvec = 0, nerr = 0;
  logic [3:0] mt [G];

  always #10 clk = ~clk;

  mtag_unit #(.GRANULES(G), .REGION_BASE(BASE)) i_mtag_unit (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input int g, input int off, input logic [3:0] t, input logic [3:0] top);
    logic [55:0] va;
    va = BASE + 56'(g * 16 + off);
    return {top, t, va};
  endfunction

  // one access; returns done/fault seen a cycle later
  task automatic access(input logic [63:0] a, input logic [3:0] lm1, input bit wr,
                        output bit d, output bit f);
    acc_addr = a; acc_len_m1 = lm1; acc_write = wr; acc_valid = 1;
    @(negedge clk);
    acc_valid = 0;
    d = acc_done; f = acc_fault;
  endtask

  task automatic range_wr(input int first, input int cnt, input logic [3:0] t, input bit zf);
    int k;
    tw_first = IW'(first); tw_count = (IW+1)'(cnt); tw_tag = t; tw_zero_fill = zf; tw_valid = 1;
    @(negedge clk);
    tw_valid = 0;
    k = 0;
    while (tw_busy && k < 200) begin
      // R8
      chk(zf_valid == zf, "R8 zf_valid", 64'(zf_valid), 64'(zf));
      if (zf) chk(zf_gran == IW'(first + k), "R8 zf_gran", 64'(zf_gran), 64'((first + k) % G));
      mt[(first + k) % G] = t;
      k++;
      @(negedge clk);
    end
    // R6
    chk(k == cnt, "R6 busy length", 64'(k), 64'(cnt));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    bit d, f, e;
    logic [3:0] t0, t1;
    logic [63:0] a1, a3;
    for (int i = 0; i < G; i++) mt[i] = 4'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!tw_busy, "R1 busy", 64'(tw_busy), 0);
    chk(!fault_pending, "R1 pending", 64'(fault_pending), 0);
    chk(!acc_done, "R1 done", 64'(acc_done), 0);
    for (int g = 0; g < G; g++) begin
      access(mk(g, 0, 4'h0, 4'h0), 4'h0, 0, d, f);
      chk(d && !f, "R1 zero tags", 64'(f), 0);
    end

    // R6 per-granule tags, count 1
    for (int g = 0; g < G; g++) range_wr(g, 1, 4'((g * 5 + 3) % 16), 0);
    // R6 count 0 is a no-op
    tw_first = 6'd4; tw_count = '0; tw_tag = 4'hF; tw_valid = 1;
    @(negedge clk);
    tw_valid = 0;
    chk(!tw_busy, "R6 zero count", 64'(tw_busy), 0);
    // R6 R8 wrapping range with zero-fill
    range_wr(62, 5, 4'h9, 1);

    // R2 R3 full sweep: every granule, every pointer tag, varying top nibble
    for (int g = 0; g < G; g++)
      for (int t = 0; t < 16; t++) begin
        access(mk(g, t, 4'(t), 4'(t + g)), 4'h0, t[0], d, f);
        e = (mt[g] != 4'(t));
        chk(d, "R3 done", 64'(d), 1);
        chk(f == e, "R2 R3 tag compare", 64'(f), 64'(e));
      end

    // R5 crossing accesses
    for (int g = 0; g < G; g++) begin
      t0 = mt[g];
      t1 = (g < G - 1) ? mt[g + 1] : t0;
      access(mk(g, 12, t0, 4'h0), 4'h7, 0, d, f);
      e = (g < G - 1) && (t1 != t0);
      chk(f == e, "R5 cross second granule", 64'(f), 64'(e));
      access(mk(g, 0, t0, 4'h0), 4'hF, 1, d, f);
      chk(!f, "R5 full granule no cross", 64'(f), 0);
    end

    // R4 outside region and disabled check
    access({8'h0F, BASE - 56'd16}, 4'h0, 0, d, f);
    chk(d && !f, "R4 below region", 64'(f), 0);
    access({8'h0F, BASE + 56'(G * 16)}, 4'h0, 0, d, f);
    chk(d && !f, "R4 above region", 64'(f), 0);
    chk_en = 0;
    access(mk(7, 0, ~mt[7], 4'h0), 4'h0, 0, d, f);
    chk(d && !f, "R4 check disabled", 64'(f), 0);
    chk_en = 1;

    // R7 stall during range write
    tw_first = 6'd20; tw_count = 7'd4; tw_tag = 4'hA; tw_zero_fill = 0; tw_valid = 1;
    @(negedge clk);
    tw_valid = 0;
    acc_addr = mk(20, 0, 4'h0, 4'h0); acc_len_m1 = 0; acc_valid = 1;
    for (int c = 0; c < 4; c++) begin
      chk(tw_busy && !acc_ready, "R7 ready low", 64'(acc_ready), 0);
      @(negedge clk);
      chk(!acc_done, "R7 no done while busy", 64'(acc_done), 0);
    end
    acc_valid = 0;
    chk(!tw_busy, "R7 busy ends", 64'(tw_busy), 0);
    for (int i = 20; i < 24; i++) mt[i] = 4'hA;

    // R9 deferred mode
    precise_mode = 0;
    a1 = mk(30, 4, ~mt[30], 4'h3);
    access(a1, 4'h0, 1, d, f);
    chk(d && !f, "R9 no precise fault", 64'(f), 0);
    chk(fault_pending, "R9 pending set", 64'(fault_pending), 1);
    chk(fault_addr == a1 && fault_write, "R9 first addr", fault_addr, a1);
    access(mk(31, 0, ~mt[31], 4'h0), 4'h0, 0, d, f);
    chk(fault_addr == a1 && fault_write, "R9 first kept", fault_addr, a1);
    fault_clr = 1;
    @(negedge clk);
    fault_clr = 0;
    chk(!fault_pending, "R9 cleared", 64'(fault_pending), 0);
    access(mk(32, 0, mt[32], 4'h0), 4'h0, 0, d, f);
    chk(!fault_pending, "R9 match leaves clear", 64'(fault_pending), 0);
    access(mk(33, 0, ~mt[33], 4'h0), 4'h0, 0, d, f);
    a3 = mk(34, 8, ~mt[34], 4'h5);
    fault_clr = 1;
    access(a3, 4'h0, 0, d, f);
    fault_clr = 0;
    chk(fault_pending && fault_addr == a3 && !fault_write, "R9 clear with new fault", fault_addr, a3);
    precise_mode = 1;

    // R10 retag makes stale pointer fault
    t0 = mt[10];
    range_wr(10, 1, t0 + 4'h1, 0);
    access(mk(10, 0, t0, 4'h0), 4'h0, 0, d, f);
    chk(f, "R10 stale pointer faults", 64'(f), 1);
    access(mk(10, 0, t0 + 4'h1, 4'h0), 4'h0, 0, d, f);
    chk(!f, "R10 new pointer passes", 64'(f), 0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule